// File: doc/BRIEF.md
# Histogram Streaming Integer Sorter

This block sorts a stream of small unsigned integers. It counts how many times each value occurs instead of comparing elements. Words arrive one per clock, qualified by a valid strobe, and a last marker flags the final word of an array. Each accepted word increments the counter of the bin that matches its value. The lowest and highest values seen, the running sum and the word count are all tracked while the array loads.

On the clock after the final word, the block starts to stream the sorted array. It walks upward from the lowest occupied bin and skips empty bins. Each value is emitted as many times as its bin counted it. While the stream runs, the block picks out the median and the most frequent value, and it empties every bin it drains. A small serial divider forms the truncated mean in parallel with the stream. When both the stream and the divider have finished, a done flag reports the minimum, maximum, median, mean and mode. All of these stay stable until the next array begins.

Two parameters set the data width, which fixes the bin count at two to the power of the width, and the longest array accepted. Words offered while the block is still busy with an array are ignored.

Top module: `hist_sort_top`

## Requirements
- R1: While idle or loading, every clock with `in_valid` high adds `in_data` to the current array, with no stall between words.
- R2: The output stream lists the kept words of the array in non-decreasing order, with each value repeated exactly as often as it was received and no other words.
- R3: `out_valid` is high in the clock cycle immediately after the edge that accepts the word marked by `in_last`, and the data of that first element is the array minimum.
- R4: `out_last` is high on the final element of the stream only, and `out_valid` is low on the following cycle.
- R5: When `stat_done` is high, `stat_min` and `stat_max` hold the smallest and largest kept words.
- R6: When `stat_done` is high, `stat_median` holds the sorted element at zero-based position floor((N-1)/2), where N is the kept word count.
- R7: When `stat_done` is high, `stat_mean` holds the sum of the kept words divided by N, truncated toward zero.
- R8: When `stat_done` is high, `stat_mode` holds the value with the largest count, and the smaller value wins a tie.
- R9: Reset is synchronous and active high, and after it `out_valid`, `stat_done` and `err_overflow` are all low.
- R10: Words offered while the sorted stream runs, or while the mean is still being computed, are ignored and do not alter the output or statistics.
- R11: Words beyond MAX_LEN in one array are dropped and set `err_overflow`, which stays high until the first word of the next array clears it.
- R12: All bins are empty once a stream completes, so consecutive arrays sort independently.
- R13: `stat_done` rises only after the stream has ended, is low while the stream is valid, and clears when the next array's first word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| in_last | input | 1 | Marks the final word of an array |
| in_data | input | DATA_W | Input value |
| out_valid | output | 1 | Sorted element strobe |
| out_last | output | 1 | Final sorted element |
| out_data | output | DATA_W | Sorted element value |
| stat_done | output | 1 | Statistics valid |
| stat_min | output | DATA_W | Smallest kept word |
| stat_max | output | DATA_W | Largest kept word |
| stat_median | output | DATA_W | Median element |
| stat_mean | output | DATA_W | Truncated mean |
| stat_mode | output | DATA_W | Most frequent value |
| err_overflow | output | 1 | Array exceeded MAX_LEN |

## Verification
The hardest case to reach from the ports is a word that arrives while the block is busy. The stream or the divider is still running, and the word must leave no trace in either the histogram or the statistics. To reach it, the bench drives random words, with random last markers, on every cycle while the sorted output is valid, and then checks that the output and statistics match only the original array. The overflow path and the tie-breaking of the mode are also hard to hit with random stimulus alone. Directed arrays cover them: one longer than the limit, one where two values tie for the highest count, and one that is then followed by a short array.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_LOAD,
        HS_OUT,
        HS_FINISH
    } hs_state_e;

    function automatic int count_width(input int max_len);
        return $clog2(max_len + 1);
    endfunction

    function automatic int sum_width(input int data_w, input int max_len);
        return data_w + count_width(max_len);
    endfunction

endpackage

// File: rtl/hs_hist_bank.sv
module hs_hist_bank #(
    parameter int BINS  = 16,
    parameter int IDX_W = 4,
    parameter int CNT_W = 7
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       inc_en,
    input  logic [IDX_W-1:0]           inc_idx,
    input  logic                       clr_en,
    input  logic [IDX_W-1:0]           clr_idx,
    output logic [BINS-1:0][CNT_W-1:0] counts,
    output logic [BINS-1:0]            occupied
);

    for (genvar g = 0; g < BINS; g++) begin : g_bin
        always_ff @(posedge clk) begin
            if (rst) begin
                counts[g] <= '0;
            end else if (clr_en && (clr_idx == IDX_W'(g))) begin
                counts[g] <= '0;
            end else if (inc_en && (inc_idx == IDX_W'(g))) begin
                counts[g] <= counts[g] + CNT_W'(1);
            end
        end
        assign occupied[g] = |counts[g];
    end

    // R1: a bin never wraps when it is incremented
    a_r1_no_wrap: assert property (@(posedge clk) disable iff (rst)
        inc_en |-> (counts[inc_idx] != {CNT_W{1'b1}}));

    // R12: a drained bin reads empty on the next cycle
    a_r12_bin_drained: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !inc_en) |=> (counts[$past(clr_idx)] == '0));

endmodule

// File: rtl/hs_bin_scan.sv
module hs_bin_scan #(
    parameter int BINS  = 16,
    parameter int IDX_W = 4
) (
    input  logic [BINS-1:0]  occ,
    input  logic [IDX_W-1:0] base_idx,
    output logic [IDX_W-1:0] nxt,
    output logic             found
);

    always_comb begin
        found = 1'b0;
        nxt   = '0;
        for (int i = BINS - 1; i >= 0; i--) begin
            if (occ[i] && (i > int'(base_idx))) begin
                found = 1'b1;
                nxt   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/hs_divider.sv
module hs_divider #(
    parameter int DIVD_W = 11,
    parameter int DIVS_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DIVD_W-1:0] dividend,
    input  logic [DIVS_W-1:0] divisor,
    output logic              done,
    output logic [DIVD_W-1:0] quotient
);

    localparam int STEP_W = $clog2(DIVD_W + 1);

    logic [DIVD_W-1:0] quo_r;
    logic [DIVS_W-1:0] rem_r;
    logic [DIVS_W-1:0] divs_r;
    logic [STEP_W-1:0] step_r;
    logic              busy_r;
    logic [DIVS_W:0]   trial;
    logic [DIVS_W:0]   rem_next;
    logic              fits;

    always_comb begin
        trial    = {rem_r, quo_r[DIVD_W-1]};
        fits     = (trial >= {1'b0, divs_r});
        rem_next = fits ? (trial - {1'b0, divs_r}) : trial;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_r  <= '0;
            rem_r  <= '0;
            divs_r <= '0;
            step_r <= '0;
            busy_r <= 1'b0;
            done   <= 1'b0;
        end else if (start) begin
            quo_r  <= dividend;
            rem_r  <= '0;
            divs_r <= divisor;
            step_r <= '0;
            busy_r <= 1'b1;
            done   <= 1'b0;
        end else if (busy_r) begin
            rem_r  <= rem_next[DIVS_W-1:0];
            quo_r  <= {quo_r[DIVD_W-2:0], fits};
            step_r <= step_r + STEP_W'(1);
            if (step_r == STEP_W'(DIVD_W - 1)) begin
                busy_r <= 1'b0;
                done   <= 1'b1;
            end
        end
    end

    assign quotient = quo_r;

    // R7: partial remainder always fits the divisor width
    a_r7_rem_fits: assert property (@(posedge clk) disable iff (rst)
        busy_r |-> !rem_next[DIVS_W]);

    // R7: final remainder is smaller than the divisor
    a_r7_rem_below: assert property (@(posedge clk) disable iff (rst)
        (done && divs_r != '0) |-> (rem_r < divs_r));

endmodule

// File: rtl/hist_sort_top.sv
module hist_sort_top
    import hs_pkg::*;
#(
    parameter int DATA_W  = 4,
    parameter int MAX_LEN = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_last,
    output logic [DATA_W-1:0] out_data,
    output logic              stat_done,
    output logic [DATA_W-1:0] stat_min,
    output logic [DATA_W-1:0] stat_max,
    output logic [DATA_W-1:0] stat_median,
    output logic [DATA_W-1:0] stat_mean,
    output logic [DATA_W-1:0] stat_mode,
    output logic              err_overflow
);

    localparam int BINS  = 1 << DATA_W;
    localparam int CNT_W = count_width(MAX_LEN);
    localparam int SUM_W = sum_width(DATA_W, MAX_LEN);

    hs_state_e st;

    logic [CNT_W-1:0]  n_cnt, n_total, med_pos, bin_used, out_cnt, best_cnt;
    logic [SUM_W-1:0]  sum_r;
    logic [DATA_W-1:0] min_r, max_r, cursor, median_r, mode_r, mean_r;
    logic              done_r, err_r;

    logic [BINS-1:0][CNT_W-1:0] bin_cnt;
    logic [BINS-1:0]            bin_occ;

    logic              accept_ok, first_w, room, take, closing;
    logic [CNT_W-1:0]  n_next, cur_cnt;
    logic [SUM_W-1:0]  sum_next;
    logic [DATA_W-1:0] min_next, max_next, scan_nxt;
    logic              scan_found, emitting, bin_end, is_last;
    logic              div_done;
    logic [SUM_W-1:0]  div_quo;

    always_comb begin
        accept_ok = in_valid && ((st == HS_IDLE) || (st == HS_LOAD));
        first_w   = (st == HS_IDLE);
        room      = first_w || (n_cnt < CNT_W'(MAX_LEN));
        take      = accept_ok && room;
        closing   = accept_ok && in_last;
        n_next    = first_w ? CNT_W'(1) : (n_cnt + (take ? CNT_W'(1) : CNT_W'(0)));
        sum_next  = (first_w ? '0 : sum_r) + (take ? SUM_W'(in_data) : '0);
        if (first_w) begin
            min_next = in_data;
            max_next = in_data;
        end else begin
            min_next = (take && (in_data < min_r)) ? in_data : min_r;
            max_next = (take && (in_data > max_r)) ? in_data : max_r;
        end
        emitting = (st == HS_OUT);
        cur_cnt  = bin_cnt[cursor];
        bin_end  = emitting && ((bin_used + CNT_W'(1)) == cur_cnt);
        is_last  = emitting && (out_cnt == (n_total - CNT_W'(1)));
    end

    hs_hist_bank #(
        .BINS  (BINS),
        .IDX_W (DATA_W),
        .CNT_W (CNT_W)
    ) bank_i (
        .clk      (clk),
        .rst      (rst),
        .inc_en   (take),
        .inc_idx  (in_data),
        .clr_en   (bin_end),
        .clr_idx  (cursor),
        .counts   (bin_cnt),
        .occupied (bin_occ)
    );

    hs_bin_scan #(
        .BINS  (BINS),
        .IDX_W (DATA_W)
    ) scan_i (
        .occ      (bin_occ),
        .base_idx (cursor),
        .nxt      (scan_nxt),
        .found    (scan_found)
    );

    hs_divider #(
        .DIVD_W (SUM_W),
        .DIVS_W (CNT_W)
    ) div_i (
        .clk      (clk),
        .rst      (rst),
        .start    (closing),
        .dividend (sum_next),
        .divisor  (n_next),
        .done     (div_done),
        .quotient (div_quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= HS_IDLE;
            n_cnt    <= '0;
            n_total  <= '0;
            med_pos  <= '0;
            bin_used <= '0;
            out_cnt  <= '0;
            best_cnt <= '0;
            sum_r    <= '0;
            min_r    <= '0;
            max_r    <= '0;
            cursor   <= '0;
            median_r <= '0;
            mode_r   <= '0;
            mean_r   <= '0;
            done_r   <= 1'b0;
            err_r    <= 1'b0;
        end else begin
            case (st)
                HS_IDLE, HS_LOAD: begin
                    if (accept_ok) begin
                        n_cnt <= n_next;
                        sum_r <= sum_next;
                        min_r <= min_next;
                        max_r <= max_next;
                        st    <= closing ? HS_OUT : HS_LOAD;
                        if (first_w) begin
                            done_r <= 1'b0;
                            err_r  <= 1'b0;
                        end else if (!room) begin
                            err_r <= 1'b1;
                        end
                        if (closing) begin
                            cursor   <= min_next;
                            n_total  <= n_next;
                            med_pos  <= (n_next - CNT_W'(1)) >> 1;
                            bin_used <= '0;
                            out_cnt  <= '0;
                            best_cnt <= '0;
                        end
                    end
                end
                HS_OUT: begin
                    out_cnt <= out_cnt + CNT_W'(1);
                    if (out_cnt == med_pos) begin
                        median_r <= cursor;
                    end
                    if (bin_end) begin
                        bin_used <= '0;
                        cursor   <= scan_nxt;
                        if (cur_cnt > best_cnt) begin
                            best_cnt <= cur_cnt;
                            mode_r   <= cursor;
                        end
                    end else begin
                        bin_used <= bin_used + CNT_W'(1);
                    end
                    if (is_last) begin
                        st <= HS_FINISH;
                    end
                end
                HS_FINISH: begin
                    if (div_done) begin
                        mean_r <= div_quo[DATA_W-1:0];
                        done_r <= 1'b1;
                        st     <= HS_IDLE;
                    end
                end
                default: st <= HS_IDLE;
            endcase
        end
    end

    assign out_valid    = emitting;
    assign out_data     = cursor;
    assign out_last     = is_last;
    assign stat_done    = done_r;
    assign stat_min     = min_r;
    assign stat_max     = max_r;
    assign stat_median  = median_r;
    assign stat_mean    = mean_r;
    assign stat_mode    = mode_r;
    assign err_overflow = err_r;

    // R3: the stream starts on the cycle after the closing word
    a_r3_stream_starts: assert property (@(posedge clk) disable iff (rst)
        closing |=> out_valid);

    // R2: consecutive stream elements never decrease
    a_r2_ascending: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> (out_data >= $past(out_data)));

    // R2: a drained bin always has an occupied successor unless the stream ends
    a_r2_next_exists: assert property (@(posedge clk) disable iff (rst)
        (bin_end && !is_last) |-> scan_found);

    // R4: the stream stops right after its last element
    a_r4_last_ends: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |=> !out_valid);

    // R12: every bin is empty whenever the block waits for a new array
    a_r12_idle_clean: assert property (@(posedge clk) disable iff (rst)
        (st == HS_IDLE) |-> (bin_occ == '0));

    // R11: the kept count never passes the limit
    a_r11_count_cap: assert property (@(posedge clk) disable iff (rst)
        (st != HS_IDLE) |-> (n_cnt <= CNT_W'(MAX_LEN)));

    // R13: statistics are never flagged done while the stream runs
    a_r13_done_quiet: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !stat_done);

    // R5: reported minimum never exceeds maximum
    a_r5_min_le_max: assert property (@(posedge clk) disable iff (rst)
        stat_done |-> (stat_min <= stat_max));

    // R7: the mean quotient fits in a data word
    a_r7_mean_fits: assert property (@(posedge clk) disable iff (rst)
        (st == HS_FINISH && div_done) |-> ((div_quo >> DATA_W) == '0));

endmodule

// File: tb/hist_sort_top_tb_top.sv
module hist_sort_top_tb_top;

    localparam int DW   = 4;
    localparam int ML   = 64;
    localparam int NBIN = 1 << DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_last = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid, out_last, stat_done, err_overflow;
    logic [DW-1:0] out_data, stat_min, stat_max, stat_median, stat_mean, stat_mode;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    hist_sort_top #(.DATA_W(DW), .MAX_LEN(ML)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_last      (in_last),
        .in_data      (in_data),
        .out_valid    (out_valid),
        .out_last     (out_last),
        .out_data     (out_data),
        .stat_done    (stat_done),
        .stat_min     (stat_min),
        .stat_max     (stat_max),
        .stat_median  (stat_median),
        .stat_mean    (stat_mean),
        .stat_mode    (stat_mode),
        .err_overflow (err_overflow)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL R13 watchdog expired actual %0d expected below 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_mode(input int s[$]);
        int best = 0;
        int val  = 0;
        for (int v = 0; v < NBIN; v++) begin
            int c = 0;
            foreach (s[i]) if (s[i] == v) c++;
            if (c > best) begin
                best = c;
                val  = v;
            end
        end
        return val;
    endfunction

    task automatic run_array(input int vals[$], input bit junk, input string tag);
        int kept[$];
        int got[$];
        int sum = 0;
        int lasts = 0;
        int last_pos = -1;
        int mism = 0;
        int done_bad = 0;
        int guard = 0;
        int n;
        for (int i = 0; i < vals.size(); i++) begin
            @(negedge clk);
            if (i == 1) begin
                check(err_overflow == 1'b0, "R11", {tag, " flag clear after first word"}, err_overflow, 0);
                check(stat_done == 1'b0, "R13", {tag, " done clear after first word"}, stat_done, 0);
            end
            in_valid = 1'b1;
            in_data  = DW'(vals[i]);
            in_last  = (i == vals.size() - 1);
            if (i < ML) kept.push_back(vals[i]);
        end
        @(negedge clk);
        check(out_valid == 1'b1, "R3", {tag, " stream starts next cycle"}, out_valid, 1);
        kept.sort();
        n = kept.size();
        check(out_data == DW'(kept[0]), "R3", {tag, " first element is minimum"}, out_data, kept[0]);
        while (out_valid && guard < 200) begin
            got.push_back(int'(out_data));
            if (stat_done) done_bad++;
            if (out_last) begin
                lasts++;
                last_pos = got.size() - 1;
            end
            if (junk) begin
                in_valid = 1'b1;
                in_data  = DW'($urandom);
                in_last  = 1'($urandom);
            end else begin
                in_valid = 1'b0;
                in_last  = 1'b0;
            end
            guard++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        check(got.size() == n, "R2", {tag, " stream length"}, got.size(), n);
        foreach (kept[i]) begin
            if (i >= got.size() || got[i] != kept[i]) mism++;
            sum += kept[i];
        end
        check(mism == 0, "R2", {tag, " sorted content mismatches"}, mism, 0);
        check(lasts == 1 && last_pos == n - 1, "R4", {tag, " last flag position"}, last_pos, n - 1);
        check(done_bad == 0, "R13", {tag, " done low during stream"}, done_bad, 0);
        guard = 0;
        while (!stat_done && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        check(stat_done == 1'b1, "R13", {tag, " done after stream"}, stat_done, 1);
        check(stat_min == DW'(kept[0]) && stat_max == DW'(kept[n-1]), "R5",
              {tag, " min/max"}, {stat_min, stat_max}, {kept[0][DW-1:0], kept[n-1][DW-1:0]});
        check(stat_median == DW'(kept[(n-1)/2]), "R6", {tag, " median"}, stat_median, kept[(n-1)/2]);
        check(stat_mean == DW'(sum / n), "R7", {tag, " mean"}, stat_mean, sum / n);
        check(stat_mode == DW'(exp_mode(kept)), "R8", {tag, " mode"}, stat_mode, exp_mode(kept));
        check(err_overflow == (vals.size() > ML), "R11", {tag, " overflow flag"},
              err_overflow, int'(vals.size() > ML));
    endtask

    initial begin
        int arr[$];
        void'($urandom(32'd2468));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && stat_done == 1'b0 && err_overflow == 1'b0, "R9",
              "outputs after reset", {out_valid, stat_done, err_overflow}, 0);

        arr = '{5};
        run_array(arr, 1'b0, "R1 single");
        arr = '{9, 9, 9, 9};
        run_array(arr, 1'b0, "R2 all equal");
        arr = '{15, 0, 15, 0, 7};
        run_array(arr, 1'b0, "R5 extremes");
        arr = '{7, 3, 7, 3, 11};
        run_array(arr, 1'b0, "R8 tie");

        arr.delete();
        for (int i = 0; i < ML; i++) arr.push_back(int'($urandom % NBIN));
        arr[3] = 0;
        arr[40] = 15;
        run_array(arr, 1'b0, "R1 full length");

        arr.delete();
        for (int i = 0; i < ML + 6; i++) arr.push_back(int'($urandom % NBIN));
        run_array(arr, 1'b0, "R11 overflow");
        arr = '{2, 1};
        run_array(arr, 1'b0, "R11 after overflow");

        arr = '{4, 12, 4, 1, 8, 8, 8, 0};
        run_array(arr, 1'b1, "R10 junk during stream");
        run_array(arr, 1'b0, "R12 repeat");
        run_array(arr, 1'b0, "R12 repeat again");

        for (int k = 0; k < 20; k++) begin
            int len  = 1 + int'($urandom % ML);
            int span = (k % 2 == 0) ? 3 : NBIN;
            int base = int'($urandom % (NBIN - span + 1));
            arr.delete();
            for (int i = 0; i < len; i++) arr.push_back(base + int'($urandom % span));
            run_array(arr, k[0], "R2 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule